// File: doc/BRIEF.md
# Selectable-Timebase Counter with Protected Mode Register

This block is a 16-bit free-running up-counter whose increment source is picked from a set of internal and external timebases: two fixed prescalers of the system clock, the raw system clock, an overflow strobe from a neighbouring timer, falling edges on an external count pin, and an external clock divided by eight. Both external pins are synchronised to the system clock before use. A wrap from all-ones to zero sets a sticky overflow flag. An interrupt request follows the flag through an enable bit.

An 8-bit mode register configures the block. Software writes it through a one-cycle write strobe and reads it back combinationally. Besides the source and the interrupt enable, it holds an idle-suspend control and a watchdog-enable bit. The watchdog bit comes up set, and while it is set it freezes the rest of the register. A companion lock bit stops the watchdog bit from being cleared until the next reset. Software clears the overflow flag with its own strobe.

Top module: `pctr_timebase`

## Requirements
- R1: During and straight after reset the counter is 0, the overflow flag and interrupt request are 0, and the mode register reads 0x40.
- R2: While mode bit 6 (watchdog enable) is 1, a write changes nothing except that bit 6 is cleared when the written bit 6 is 0 and bit 5 is 0.
- R3: Mode bit 4 always reads 0, whatever value is written to it.
- R4: Mode bit 5 (lock), once written to 1, stays 1 until reset; while it is 1, bit 6 can be set but not cleared.
- R5: With source field bits 3:1 = 100, the counter advances by one on every system clock.
- R6: Source 001 advances the counter once per 4 system clocks; source 000 advances it once per 12.
- R7: Source 010 advances the counter once for each cycle in which the timer-0 overflow strobe is high.
- R8: Source 011 counts synchronised falling edges of the external count pin; accepted edges are at least 4 clocks apart, and an edge inside that gap is dropped.
- R9: Source 101 advances the counter once per 8 synchronised rising edges of the external clock pin.
- R10: Source codes 110 and 111 leave the counter unchanged.
- R11: When mode bit 7 is 1 and the CPU idle input is 1, the counter holds; when bit 7 is 0, idle has no effect on counting.
- R12: A counter wrap from 0xFFFF to 0x0000 sets the overflow flag on that edge; the flag stays set until the clear strobe is pulsed.
- R13: The interrupt request is high exactly when the overflow flag is 1 and mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read value |
| flag_clr | input | 1 | Overflow flag clear strobe |
| cpu_idle | input | 1 | CPU is in idle mode |
| t0_ovf | input | 1 | Timer-0 overflow strobe |
| eci_in | input | 1 | External count pin (falling edges counted) |
| ext_clk_in | input | 1 | External clock pin |
| count_q | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A mode write is visible on the read port at the first sample after the edge that takes the strobe, and the new source takes over from the following edge. Increments from the system clock, prescalers and timer-0 strobe land one edge after the qualifying cycle. The flag sets on the wrap edge, and the interrupt follows it in the same cycle. The external pins cross three register stages before they can count, so for those sources the checks are scheduled well after the stimulus and compare the total count over a window. Every expected item is queued with the exact cycle it is due, and the monitor compares it at the falling edge of that cycle.

// File: rtl/pctr_timebase.sv
module pctr_timebase #(
  parameter int          CW          = 16,
  parameter logic [7:0]  RST_MODE    = 8'h40,
  parameter int          SLOW_DIV    = 12,
  parameter int          FAST_DIV    = 4,
  parameter int          ECI_GAP     = 4,
  parameter int          EXT_DIV     = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          flag_clr,
  input  logic          cpu_idle,
  input  logic          t0_ovf,
  input  logic          eci_in,
  input  logic          ext_clk_in,
  output logic [CW-1:0] count_q,
  output logic          ovf_flag,
  output logic          irq
);
  localparam int SW = $clog2(SLOW_DIV);
  localparam int FW = $clog2(FAST_DIV);
  localparam int GW = $clog2(ECI_GAP);
  localparam int EW = $clog2(EXT_DIV);

  logic [7:0] mode;
  wire idle_hold = mode[7];
  wire wd_en     = mode[6];
  wire wd_lock   = mode[5];
  wire [2:0] src = mode[3:1];
  wire ovf_ie    = mode[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= RST_MODE;
    end else if (reg_we) begin
      if (wd_en) begin
        if (!reg_wdata[6] && !wd_lock) mode[6] <= 1'b0;
      end else begin
        mode <= {reg_wdata[7:6], wd_lock | reg_wdata[5], 1'b0, reg_wdata[3:0]};
      end
    end
  end

  assign reg_rdata = mode;

  logic [SW-1:0] slow_cnt;
  logic [FW-1:0] fast_cnt;
  wire slow_tick = (slow_cnt == SW'(SLOW_DIV - 1));
  wire fast_tick = (fast_cnt == FW'(FAST_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_cnt <= '0;
      fast_cnt <= '0;
    end else begin
      slow_cnt <= slow_tick ? '0 : slow_cnt + 1'b1;
      fast_cnt <= fast_tick ? '0 : fast_cnt + 1'b1;
    end
  end

  logic [SYNC_STAGES:0] eci_sh, ext_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eci_sh <= '0;
      ext_sh <= '0;
    end else begin
      eci_sh <= {eci_sh[SYNC_STAGES-1:0], eci_in};
      ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk_in};
    end
  end

  wire eci_fall = eci_sh[SYNC_STAGES] & ~eci_sh[SYNC_STAGES-1];
  wire ext_rise = ~ext_sh[SYNC_STAGES] & ext_sh[SYNC_STAGES-1];

  logic [GW-1:0] eci_guard;
  wire eci_take = eci_fall && (eci_guard == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                eci_guard <= '0;
    else if (eci_take)         eci_guard <= GW'(ECI_GAP - 1);
    else if (eci_guard != '0)  eci_guard <= eci_guard - 1'b1;
  end

  logic [EW-1:0] ext_cnt;
  wire ext_tick = ext_rise && (ext_cnt == EW'(EXT_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ext_cnt <= '0;
    else if (ext_rise) ext_cnt <= ext_cnt + 1'b1;
  end

  logic src_tick;
  always_comb begin
    case (src)
      3'b000:  src_tick = slow_tick;
      3'b001:  src_tick = fast_tick;
      3'b010:  src_tick = t0_ovf;
      3'b011:  src_tick = eci_take;
      3'b100:  src_tick = 1'b1;
      3'b101:  src_tick = ext_tick;
      default: src_tick = 1'b0;
    endcase
  end

  wire step = src_tick && !(idle_hold && cpu_idle);
  wire wrap = step && (&count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (step) count_q <= count_q + 1'b1;
      if (wrap)          ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
    end
  end

  assign irq = ovf_flag & ovf_ie;
endmodule

// File: rtl/pctr_timebase_props.sv
module pctr_timebase_props #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          cpu_idle,
  input logic [7:0]    reg_rdata,
  input logic [CW-1:0] count_q,
  input logic          ovf_flag,
  input logic          flag_clr
);
  AST_WD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[6] && reg_we) |=> ((reg_rdata & 8'hBF) == $past(reg_rdata & 8'hBF))); // R2

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] |=> reg_rdata[5]); // R4

  AST_LOCK_KEEPS_WD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[5] && reg_rdata[6]) |=> reg_rdata[6]); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> (count_q == CW'($past(count_q) + 1'b1))); // R5

  AST_ECI_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata[3:1] == 3'b011) && $stable(reg_rdata) && (count_q != $past(count_q)))
      |=> (count_q == $past(count_q))); // R8

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3:2] == 2'b11) |=> (count_q == $past(count_q))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && cpu_idle) |=> (count_q == $past(count_q))); // R11

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count_q) ##1 (count_q == '0)) |-> ovf_flag); // R12

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R12
endmodule

bind pctr_timebase pctr_timebase_props #(.CW(CW)) u_props (.*);

// File: tb/pctr_timebase_bench.sv
`timescale 1ns/1ps
module pctr_timebase_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        flag_clr = 1'b0;
  logic        cpu_idle = 1'b0;
  logic        t0_ovf = 1'b0;
  logic        eci_in = 1'b1;
  logic        ext_clk_in = 1'b0;
  logic [15:0] count_q;
  logic        ovf_flag;
  logic        irq;

  always #4 clk = ~clk;

  pctr_timebase u_pctr_timebase (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flag_clr(flag_clr), .cpu_idle(cpu_idle),
    .t0_ovf(t0_ovf), .eci_in(eci_in), .ext_clk_in(ext_clk_in),
    .count_q(count_q), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    while (sb.size() != 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      case (it.sel)
        0: act = {16'h0, count_q};
        1: act = {31'h0, ovf_flag};
        2: act = {31'h0, irq};
        default: act = {24'h0, reg_rdata};
      endcase
      compared++;
      if (it.due != cyc || act !== it.exp) begin
        mismatched++;
        $display("FAIL %s sel=%0d actual=%h expected=%h (due %0d, at %0d)",
                 it.req, it.sel, act, it.exp, it.due, cyc);
      end
    end
  end

  function automatic void push(int off, int sel, logic [31:0] exp, string req);
    sb.push_back('{cyc + off, sel, exp, req});
  endfunction

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_idle = 1'b0; t0_ovf = 1'b0; eci_in = 1'b1; ext_clk_in = 1'b0; flag_clr = 1'b0;
    tick(1);
    push(1, 0, 32'h0, "R1 count");
    push(1, 1, 32'h0, "R1 flag");
    push(1, 2, 32'h0, "R1 irq");
    push(1, 3, 32'h40, "R1 mode");
    drain();
    rst_n = 1'b1;
    push(1, 3, 32'h40, "R1 mode after release");
    drain();
  endtask

  task automatic expect_delta(int win, int d, string req);
    logic [15:0] c0;
    c0 = count_q;
    push(win, 0, {16'h0, c0 + 16'(d)}, req);
    drain();
  endtask

  initial begin
    logic [15:0] c0;
    int n;
    tick(2);
    do_reset();

    // R2: frozen register, only watchdog bit may clear
    wr(8'hFF); push(1, 3, 32'h40, "R2 write ignored"); drain();
    wr(8'h8F); push(1, 3, 32'h00, "R2 only bit6 cleared"); drain();
    // R3
    wr(8'h1F); push(1, 3, 32'h0F, "R3 bit4 reads zero"); drain();

    // R5 system clock
    wr(8'h08); expect_delta(20, 20, "R5 sysclk");
    // R6 prescalers
    wr(8'h02); tick(1); expect_delta(40, 10, "R6 div4");
    wr(8'h00); tick(1); expect_delta(48, 4, "R6 div12");

    // R7 timer-0 strobe
    wr(8'h04);
    c0 = count_q;
    for (int i = 0; i < 5; i++) begin
      t0_ovf = 1'b1; tick(1); t0_ovf = 1'b0; tick(2);
    end
    push(3, 0, {16'h0, c0 + 16'd5}, "R7 t0 strobes"); drain();

    // R8 external count pin
    wr(8'h06); tick(6);
    c0 = count_q;
    for (int i = 0; i < 10; i++) begin
      eci_in = 1'b0; tick(1); eci_in = 1'b1; tick(1);
    end
    tick(8);
    for (int i = 0; i < 3; i++) begin
      eci_in = 1'b0; tick(4); eci_in = 1'b1; tick(4);
    end
    push(8, 0, {16'h0, c0 + 16'd8}, "R8 eci edges with gap"); drain();

    // R9 external clock / 8
    wr(8'h0A); tick(2);
    c0 = count_q;
    for (int i = 0; i < 16; i++) begin
      ext_clk_in = 1'b1; tick(2); ext_clk_in = 1'b0; tick(2);
    end
    push(8, 0, {16'h0, c0 + 16'd2}, "R9 ext clock div8"); drain();

    // R10 reserved
    wr(8'h0C); expect_delta(30, 0, "R10 code 110");
    wr(8'h0E); expect_delta(30, 0, "R10 code 111");

    // R11 idle control
    wr(8'h88); cpu_idle = 1'b1; expect_delta(10, 0, "R11 idle suspend");
    cpu_idle = 1'b0; expect_delta(10, 10, "R11 idle released");
    wr(8'h08); cpu_idle = 1'b1; expect_delta(10, 10, "R11 idle ignored");
    cpu_idle = 1'b0;

    // R12/R13 overflow
    c0 = count_q;
    n = 65536 - int'(c0);
    push(n - 1, 0, 32'hFFFF, "R12 before wrap");
    push(n - 1, 1, 32'h0, "R12 flag before wrap");
    push(n, 0, 32'h0, "R12 wrapped");
    push(n, 1, 32'h1, "R12 flag set");
    push(n, 2, 32'h0, "R13 irq masked");
    drain();
    push(6, 1, 32'h1, "R12 flag sticky"); drain();
    wr(8'h09); push(1, 2, 32'h1, "R13 irq enabled"); drain();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    push(1, 1, 32'h0, "R12 flag cleared");
    push(1, 2, 32'h0, "R13 irq drops"); drain();

    // R4 lock
    wr(8'h20); push(1, 3, 32'h20, "R4 lock set"); drain();
    wr(8'h00); push(1, 3, 32'h20, "R4 lock sticky"); drain();
    wr(8'h60); push(1, 3, 32'h60, "R4 wd set under lock"); drain();
    wr(8'h00); push(1, 3, 32'h60, "R4 wd not clearable"); drain();
    do_reset();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule